// File: doc/BRIEF.md
# Two-Speed Limiter Gain Controller

This block is the digital part of a speaker-protection limiter. It sets the gain-cut code for an amplifier gain stage. Two comparators outside the block each supply one flag per sample. One flag reports clipping at the output. The other reports that the output is above the constant-power threshold. The block does its timing on a slow clock-enable tick, nominally 1 MHz. While clipping is present it raises the cut at a fast rate. While the output is only over the threshold it raises the cut at a slow rate. When both flags are clear it lowers the cut back towards unity at a much slower release rate.

The cut is a code in 0.5 dB steps, from 0 (no cut) up to a ceiling of 13.5 dB. The default step intervals give these figures:
- 10 dB of fast cut in 1.5 ms.
- 3.5 dB of slow cut in 6 ms.
- A full 13.5 dB recovery in 280 ms.

A mode input turns limiting on or off. With limiting off, the gain stage runs uncut.

Top module: `lim_gain_ctrl`

## Requirements
- R1: After reset, atten_o is 0 and busy_o is 0.
- R2: atten_o counts 0.5 dB per LSB. It never exceeds MAX_CODE (default 27, i.e. 13.5 dB). In one clock it changes by at most one step, unless the limiter is forced to zero by the mode.
- R3: With limiting enabled, a tick with clip_i high puts the controller in fast attack. After the entry tick, every FAST_DIV further ticks in fast attack add one step.
- R4: A tick with clip_i low and over_i high puts the controller in slow attack. After the entry tick, every SLOW_DIV further ticks in slow attack add one step.
- R5: A tick with both flags low, taken in release, keeps the release going. Every REL_DIV release ticks after the entry tick remove one step. The first tick in release that finds the code at 0 returns the controller to idle.
- R6: A tick with both flags low, taken during fast or slow attack, leaves the code unchanged. That tick moves the controller to release.
- R7: Any change of rate restarts the step interval. If clip_i is high on a tick during slow attack or release, the controller switches to fast attack on that same tick.
- R8: Limiting is enabled only for mode_i values 1 to 7. Any other value clears atten_o to 0 and busy_o to 0 at the next clock edge, whether or not a tick is present. These modes then ignore both flags.
- R9: busy_o is high exactly while the controller is in fast attack, slow attack or release. If atten_o is nonzero, busy_o is high.
- R10: On clocks with tick_i low, neither the code nor the controller state changes, unless the mode disables limiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable for the step timing (nominally 1 MHz) |
| mode_i | input | MODE_W | Operating mode; values 1..7 enable limiting |
| clip_i | input | 1 | Clipping detected at the output |
| over_i | input | 1 | Output above the constant-power threshold |
| atten_o | output | CODE_W | Gain cut in 0.5 dB steps |
| busy_o | output | 1 | Controller is attacking or releasing |

## Verification
The bench aims at the handovers between rates.

- **Fast to slow and back to fast.** A design that kept its old counter across a handover would step early.
- **Attack to hold.** A design that released on the hold tick would drop a step too soon.
- **Ceiling at 27.** A design that wrapped there would jump to 0.
- **Release to idle.** A design that missed this step would stay busy with no cut.
- **Mode changes.** It changes the mode to a non-limiting value with no tick present. A synchronous clear gated by the tick would leave the cut in place.
- **Gaps between ticks.** A design that counted clocks instead of ticks would run far too fast.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FAST = 2'd1,
    ST_SLOW = 2'd2,
    ST_REL  = 2'd3
  } lim_state_e;
endpackage

// File: rtl/lim_fsm.sv
module lim_fsm
  import lim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       clip_i,
  input  logic       over_i,
  input  logic       zero_i,
  output lim_state_e state_o,
  output logic       switch_o
);
  lim_state_e state_q, state_d;

  always_comb begin
    if (clip_i)      state_d = ST_FAST;
    else if (over_i) state_d = ST_SLOW;
    else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_REL:  state_d = zero_i ? ST_IDLE : ST_REL;
        default: state_d = ST_REL; // attack with no flag: hold this tick
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_IDLE;
    else if (!en_i)  state_q <= ST_IDLE;
    else if (tick_i) state_q <= state_d;
  end

  assign state_o  = state_q;
  assign switch_o = en_i && tick_i && (state_d != state_q);

  AST_CLIP_GOES_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && clip_i) |=> (state_q == ST_FAST)); // R7
  AST_OFF_IS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE)); // R8
  AST_NO_TICK_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(state_q)); // R10
endmodule

// File: rtl/lim_step_timer.sv
module lim_step_timer
  import lim_pkg::*;
#(
  parameter int unsigned FAST_DIV = 75,
  parameter int unsigned SLOW_DIV = 857,
  parameter int unsigned REL_DIV  = 10370
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       restart_i,
  input  lim_state_e state_i,
  output logic       step_o
);
  localparam int unsigned MAX_AB  = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int unsigned MAX_DIV = (MAX_AB > REL_DIV) ? MAX_AB : REL_DIV;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] REL_LIM  = CNT_W'(REL_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             active, at_lim;

  always_comb begin
    unique case (state_i)
      ST_FAST: lim = FAST_LIM;
      ST_SLOW: lim = SLOW_LIM;
      default: lim = REL_LIM;
    endcase
  end

  assign active = (state_i != ST_IDLE);
  assign at_lim = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!en_i)                cnt_q <= '0;
    else if (tick_i) begin
      if (restart_i || !active)    cnt_q <= '0;
      else if (at_lim)             cnt_q <= '0;
      else                         cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign step_o = en_i && tick_i && !restart_i && active && at_lim;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim || $past(state_i) != state_i); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/lim_atten_reg.sv
module lim_atten_reg
  import lim_pkg::*;
#(
  parameter int unsigned MAX_CODE = 27,
  localparam int unsigned CODE_W  = $clog2(MAX_CODE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  lim_state_e        state_i,
  output logic [CODE_W-1:0] code_o,
  output logic              zero_o
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (!en_i)   code_q <= '0;
    else if (step_i) begin
      if (state_i == ST_REL) begin
        if (code_q != '0) code_q <= code_q - CODE_W'(1);
      end else if (code_q != TOP) begin
        code_q <= code_q + CODE_W'(1);
      end
    end
  end

  assign code_o = code_q;
  assign zero_o = (code_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= TOP); // R2
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + CODE_W'(1))
             || (code_q + CODE_W'(1) == $past(code_q)) || (code_q == '0)); // R2
  AST_NO_TICK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> $stable(code_q)); // R10
endmodule

// File: rtl/lim_gain_ctrl.sv
module lim_gain_ctrl
  import lim_pkg::*;
#(
  parameter int unsigned MODE_W      = 4,
  parameter int unsigned LIM_MODE_LO = 1,
  parameter int unsigned LIM_MODE_HI = 7,
  parameter int unsigned MAX_CODE    = 27,
  parameter int unsigned FAST_DIV    = 75,
  parameter int unsigned SLOW_DIV    = 857,
  parameter int unsigned REL_DIV     = 10370,
  localparam int unsigned CODE_W     = $clog2(MAX_CODE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              clip_i,
  input  logic              over_i,
  output logic [CODE_W-1:0] atten_o,
  output logic              busy_o
);
  logic       limit_en, zero, restart, step;
  lim_state_e state;

  assign limit_en = (mode_i >= MODE_W'(LIM_MODE_LO)) && (mode_i <= MODE_W'(LIM_MODE_HI));

  lim_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (limit_en),
    .tick_i   (tick_i),
    .clip_i   (clip_i),
    .over_i   (over_i),
    .zero_i   (zero),
    .state_o  (state),
    .switch_o (restart)
  );

  lim_step_timer #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV),
    .REL_DIV  (REL_DIV)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (limit_en),
    .tick_i    (tick_i),
    .restart_i (restart),
    .state_i   (state),
    .step_o    (step)
  );

  lim_atten_reg #(
    .MAX_CODE (MAX_CODE)
  ) i_atten (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (limit_en),
    .step_i  (step),
    .state_i (state),
    .code_o  (atten_o),
    .zero_o  (zero)
  );

  assign busy_o = (state != ST_IDLE);

  AST_FORCE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !limit_en |=> (atten_o == '0) && !busy_o); // R8
  AST_BUSY_WHEN_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atten_o != '0) |-> busy_o); // R9
  AST_IDLE_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && tick_i && !clip_i && !over_i) |=> !busy_o); // R5
endmodule

// File: tb/test_lim_gain_ctrl.sv
module test_lim_gain_ctrl;
  localparam int FD = 3, SD = 5, RD = 7, MAXC = 27;

  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, clip = 1'b0, over = 1'b0;
  logic [3:0] mode = 4'd1;
  logic [4:0] atten;
  logic       busy;

  always #2 clk = ~clk;

  lim_gain_ctrl #(.FAST_DIV(FD), .SLOW_DIV(SD), .REL_DIV(RD), .MAX_CODE(MAXC)) i_lim_gain_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .mode_i(mode),
    .clip_i(clip), .over_i(over), .atten_o(atten), .busy_o(busy));

  typedef struct { int code; bit busy; string tag; } exp_t;
  exp_t q[$];
  event chk_ev;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference: 0 idle, 1 fast, 2 slow, 3 release
  int m_st = 0, m_cnt = 0, m_code = 0;

  function automatic void model(input bit c, input bit o, input int md, input bit tk);
    int nxt, lim;
    if (md < 1 || md > 7) begin m_st = 0; m_cnt = 0; m_code = 0; return; end
    if (!tk) return;
    if (c) nxt = 1;
    else if (o) nxt = 2;
    else if (m_st == 0) nxt = 0;
    else if (m_st == 3) nxt = (m_code == 0) ? 0 : 3;
    else nxt = 3;
    if (nxt != m_st) begin m_st = nxt; m_cnt = 0; end
    else if (m_st != 0) begin
      lim = (m_st == 1) ? FD : (m_st == 2) ? SD : RD;
      if (m_cnt == lim - 1) begin
        m_cnt = 0;
        if (m_st == 3) begin if (m_code > 0) m_code--; end
        else if (m_code < MAXC) m_code++;
      end else m_cnt++;
    end
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.code = m_code; e.busy = (m_st != 0); e.tag = tag;
    q.push_back(e);
    -> chk_ev;
  endtask

  // one clock with given inputs, then sample; tick dropped before next edge
  task automatic apply(input bit c, input bit o, input int md, input bit tk, input string tag);
    @(negedge clk);
    clip = c; over = o; mode = 4'(md); tick = tk;
    @(negedge clk);
    model(c, o, md, tk);
    tick = 1'b0;
    model(c, o, md, 1'b0);
    push(tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (atten !== 5'(e.code)) begin
          errors++;
          $display("FAIL %s: atten_o actual %0d expected %0d", e.tag, atten, e.code);
        end
        checks++;
        if (busy !== e.busy) begin
          errors++;
          $display("FAIL R9 (%s): busy_o actual %0b expected %0b", e.tag, busy, e.busy);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    push("R1");
    apply(0, 0, 1, 1, "R1");
    // fast attack from idle
    for (int i = 0; i < 30; i++) apply(1, 0, 1, 1, "R3");
    // clock gaps without tick
    for (int i = 0; i < 5; i++) apply(1, 1, 1, 0, "R10");
    // handover to slow
    for (int i = 0; i < 12; i++) apply(0, 1, 1, 1, "R4");
    // clip during slow attack
    for (int i = 0; i < 4; i++) apply(1, 1, 1, 1, "R7");
    // hold tick then release to idle
    apply(0, 0, 1, 1, "R6");
    for (int i = 0; i < 120; i++) begin
      apply(0, 0, 1, 1, "R5");
      if (i % 9 == 0) apply(0, 0, 1, 0, "R10");
    end
    // saturation at the ceiling
    for (int i = 0; i < 100; i++) apply(1, 1, 7, 1, "R2");
    // release part way, then clip returns
    apply(0, 0, 7, 1, "R6");
    for (int i = 0; i < 16; i++) apply(0, 0, 7, 1, "R5");
    for (int i = 0; i < 8; i++) apply(1, 0, 7, 1, "R7");
    // non-limiting mode with no tick clears the cut
    apply(1, 1, 8, 0, "R8");
    for (int md = 8; md < 16; md++) apply(1, 1, md, 1, "R8");
    apply(1, 0, 0, 1, "R8");
    // limiting resumes in mode 4
    for (int i = 0; i < 7; i++) apply(1, 0, 4, 1, "R3");
    apply(0, 0, 4, 1, "R6");
    apply(0, 0, 4, 1, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule